// File: doc/BRIEF.md
# Counter Loop Branch Execution Unit

This unit executes a three-byte loop-control instruction for a small 8/16-bit processor. A start strobe brings in the byte that follows the opcode (the control byte), the low byte of the branch displacement, the address at which the instruction begins, and the current contents of the registers A, B, X, Y and SP. The 16-bit register D is not held separately. It is formed as A in the high byte and B in the low byte.

The control byte selects one of three operations on a counter register: decrement, increment, or test only. The unit writes the new count back through a register-file write port, checks whether the count is zero, and chooses whether to branch. A taken branch gives a next PC of the start address plus three plus the sign-extended 9-bit displacement. A branch that is not taken gives the start address plus three. The unit does not touch the condition flags.

The result appears exactly three clock cycles after the start strobe is accepted, marked by a one-cycle done pulse. Encodings that have no meaning are reported on an illegal flag, and in that case nothing is written.

Top module: `loop_branch_unit`

## Requirements
- R1: Control byte bits 2:0 choose the counter: 000=A, 001=B, 100=D, 101=X, 110=Y, 111=SP. The write enables are wr_en[0]=A, wr_en[1]=B, wr_en[2]=X, wr_en[3]=Y, wr_en[4]=SP. A write to D raises both A and B, with wr_a carrying the high byte and wr_b the low byte.
- R2: Control byte bits 7:6 choose the operation: 00 subtracts one, 10 adds one, 01 only tests the value and writes nothing (wr_en stays 0).
- R3: For A and B the result and the zero test are 8 bits wide and wrap modulo 256. The other byte register is not written. For D, X, Y and SP they are 16 bits wide and wrap modulo 65536.
- R4: Control byte bit 5 sets the branch sense. With 0, the branch is taken when the result is zero. With 1, it is taken when the result is non-zero. The taken output shows the decision.
- R5: The displacement is a 9-bit two's-complement value, with control byte bit 4 as its sign and offset_lo as its low 8 bits (range -256..+255). When taken, next_pc = pc + 3 + displacement. When not taken, next_pc = pc + 3. Both are computed modulo 65536.
- R6: Control byte bit 3 has no effect on any output.
- R7: Bits 7:6 = 11, or a register code of 010 or 011, is illegal. In that case illegal is 1 together with done, wr_en is 0, taken is 0 and next_pc equals pc.
- R8: When start is accepted at a clock edge, done is high for exactly one cycle after the third edge that follows. wr_en and illegal are non-zero only in that cycle.
- R9: A start strobe that arrives while an instruction is in progress is ignored. It neither changes the pending result nor produces an extra done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing the presented instruction |
| postbyte | input | 8 | Control byte: operation, sense, sign, register |
| offset_lo | input | 8 | Low 8 bits of the branch displacement |
| pc | input | 16 | Address of the first byte of the instruction |
| reg_a | input | 8 | Current value of A |
| reg_b | input | 8 | Current value of B |
| reg_x | input | 16 | Current value of X |
| reg_y | input | 16 | Current value of Y |
| reg_sp | input | 16 | Current value of SP |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal encoding, valid with done |
| taken | output | 1 | Branch decision, valid with done |
| next_pc | output | 16 | Next instruction address, valid with done |
| wr_en | output | 5 | Write enables {SP,Y,X,B,A} |
| wr_a | output | 8 | New value for A |
| wr_b | output | 8 | New value for B |
| wr_w | output | 16 | New value for X, Y or SP |

## Verification
Directed cases drive the counter across its wrap points. A at zero being decremented shows an 8-bit wrap apart from a 16-bit one. D at 0x0100 shows the borrow carried from B into A. X at 0xFFFF being incremented shows the carry-out wrap. Both branch senses are run on a zero and a non-zero result, so that a swapped polarity or a zero test of the wrong width is caught. Displacements of -256 and +255 near both ends of the address space expose sign-extension and PC-wrap errors. Paired runs that differ only in bit 3, the illegal codes, and a second start while busy each check that an input has no effect. A seeded random stream then covers all operation, register and sense combinations against a bench model.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 16;
    localparam int INSN_LEN = 3;
    localparam int N_WE     = 5;

    localparam int WE_A  = 0;
    localparam int WE_B  = 1;
    localparam int WE_X  = 2;
    localparam int WE_Y  = 3;
    localparam int WE_SP = 4;

    typedef enum logic [1:0] {
        OP_DEC = 2'b00,
        OP_TST = 2'b01,
        OP_INC = 2'b10,
        OP_BAD = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        SEL_A   = 3'b000,
        SEL_B   = 3'b001,
        SEL_R2  = 3'b010,
        SEL_R3  = 3'b011,
        SEL_D   = 3'b100,
        SEL_X   = 3'b101,
        SEL_Y   = 3'b110,
        SEL_SP  = 3'b111
    } sel_e;

    typedef struct packed {
        op_e  op;
        logic on_nonzero;
        logic off_sign;
        sel_e sel;
        logic narrow;
        logic illegal;
    } dec_t;

    typedef struct packed {
        logic [BYTE_W-1:0] pb;
        logic [BYTE_W-1:0] off;
        logic [WORD_W-1:0] pc;
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
        logic [WORD_W-1:0] x;
        logic [WORD_W-1:0] y;
        logic [WORD_W-1:0] sp;
    } snap_t;

    function automatic dec_t decode_ctl(input logic [BYTE_W-1:0] pb);
        dec_t d;
        d.op         = op_e'(pb[7:6]);
        d.on_nonzero = pb[5];
        d.off_sign   = pb[4];
        d.sel        = sel_e'(pb[2:0]);
        d.narrow     = (d.sel == SEL_A) || (d.sel == SEL_B);
        d.illegal    = (d.op == OP_BAD) || (d.sel == SEL_R2) || (d.sel == SEL_R3);
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] sext9(input logic sign, input logic [BYTE_W-1:0] lo);
        return {{(WORD_W-BYTE_W){sign}}, lo};
    endfunction

endpackage

// File: rtl/lbu_decode.sv
module lbu_decode
    import lbu_pkg::*;
(
    input  logic [BYTE_W-1:0] ctl,
    output dec_t              dec
);
    always_comb begin
        dec = decode_ctl(ctl);
    end
endmodule

// File: rtl/lbu_count.sv
module lbu_count
    import lbu_pkg::*;
(
    input  dec_t              dec,
    input  snap_t             snap,
    output logic              is_zero,
    output logic [N_WE-1:0]   we,
    output logic [BYTE_W-1:0] new_a,
    output logic [BYTE_W-1:0] new_b,
    output logic [WORD_W-1:0] new_w
);
    logic [WORD_W-1:0] operand;
    logic [WORD_W-1:0] result;

    always_comb begin
        unique case (dec.sel)
            SEL_A:   operand = {{(WORD_W-BYTE_W){1'b0}}, snap.a};
            SEL_B:   operand = {{(WORD_W-BYTE_W){1'b0}}, snap.b};
            SEL_D:   operand = {snap.a, snap.b};
            SEL_X:   operand = snap.x;
            SEL_Y:   operand = snap.y;
            SEL_SP:  operand = snap.sp;
            default: operand = '0;
        endcase
    end

    always_comb begin
        unique case (dec.op)
            OP_DEC:  result = operand - 1'b1;
            OP_INC:  result = operand + 1'b1;
            default: result = operand;
        endcase
        if (dec.narrow) begin
            result[WORD_W-1:BYTE_W] = '0;
        end
    end

    assign is_zero = (result == '0);

    always_comb begin
        we    = '0;
        new_a = '0;
        new_b = '0;
        new_w = '0;
        if (!dec.illegal && dec.op != OP_TST) begin
            unique case (dec.sel)
                SEL_A: begin
                    we[WE_A] = 1'b1;
                    new_a    = result[BYTE_W-1:0];
                end
                SEL_B: begin
                    we[WE_B] = 1'b1;
                    new_b    = result[BYTE_W-1:0];
                end
                SEL_D: begin
                    we[WE_A] = 1'b1;
                    we[WE_B] = 1'b1;
                    new_a    = result[WORD_W-1:BYTE_W];
                    new_b    = result[BYTE_W-1:0];
                end
                SEL_X: begin
                    we[WE_X] = 1'b1;
                    new_w    = result;
                end
                SEL_Y: begin
                    we[WE_Y] = 1'b1;
                    new_w    = result;
                end
                SEL_SP: begin
                    we[WE_SP] = 1'b1;
                    new_w     = result;
                end
                default: we = '0;
            endcase
        end
    end
endmodule

// File: rtl/lbu_target.sv
module lbu_target
    import lbu_pkg::*;
(
    input  dec_t              dec,
    input  logic [BYTE_W-1:0] off_lo,
    input  logic [WORD_W-1:0] start_pc,
    input  logic              take,
    output logic [WORD_W-1:0] target
);
    logic [WORD_W-1:0] fall_through;

    assign fall_through = start_pc + WORD_W'(INSN_LEN);

    always_comb begin
        if (dec.illegal) begin
            target = start_pc;
        end else if (take) begin
            target = fall_through + sext9(dec.off_sign, off_lo);
        end else begin
            target = fall_through;
        end
    end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import lbu_pkg::*;
#(
    parameter int LATENCY = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [7:0]  postbyte,
    input  logic [7:0]  offset_lo,
    input  logic [15:0] pc,
    input  logic [7:0]  reg_a,
    input  logic [7:0]  reg_b,
    input  logic [15:0] reg_x,
    input  logic [15:0] reg_y,
    input  logic [15:0] reg_sp,
    output logic        done,
    output logic        illegal,
    output logic        taken,
    output logic [15:0] next_pc,
    output logic [4:0]  wr_en,
    output logic [7:0]  wr_a,
    output logic [7:0]  wr_b,
    output logic [15:0] wr_w
);
    localparam int CNT_W = (LATENCY > 2) ? $clog2(LATENCY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LATENCY - 1);

    snap_t              snap;
    logic               busy;
    logic [CNT_W-1:0]   cnt;
    logic               accept;
    logic               finish;

    dec_t               dec;
    logic               is_zero;
    logic               take;
    logic [N_WE-1:0]    we_c;
    logic [BYTE_W-1:0]  a_c;
    logic [BYTE_W-1:0]  b_c;
    logic [WORD_W-1:0]  w_c;
    logic [WORD_W-1:0]  tgt_c;

    assign accept = start && !busy;
    assign finish = busy && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            snap <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            cnt  <= '0;
            snap <= '{pb: postbyte, off: offset_lo, pc: pc, a: reg_a,
                      b: reg_b, x: reg_x, y: reg_y, sp: reg_sp};
        end else if (finish) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt  <= cnt + 1'b1;
        end
    end

    lbu_decode u_dec (
        .ctl (snap.pb),
        .dec (dec)
    );

    lbu_count u_cnt (
        .dec     (dec),
        .snap    (snap),
        .is_zero (is_zero),
        .we      (we_c),
        .new_a   (a_c),
        .new_b   (b_c),
        .new_w   (w_c)
    );

    assign take = !dec.illegal && (dec.on_nonzero ? !is_zero : is_zero);

    lbu_target u_tgt (
        .dec      (dec),
        .off_lo   (snap.off),
        .start_pc (snap.pc),
        .take     (take),
        .target   (tgt_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            illegal <= 1'b0;
            taken   <= 1'b0;
            next_pc <= '0;
            wr_en   <= '0;
            wr_a    <= '0;
            wr_b    <= '0;
            wr_w    <= '0;
        end else if (finish) begin
            done    <= 1'b1;
            illegal <= dec.illegal;
            taken   <= take;
            next_pc <= tgt_c;
            wr_en   <= we_c;
            wr_a    <= a_c;
            wr_b    <= b_c;
            wr_w    <= w_c;
        end else begin
            done    <= 1'b0;
            illegal <= 1'b0;
            wr_en   <= '0;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                            // R8
    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));                               // R8
    AST_WR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (wr_en != '0 || illegal) |-> done);                         // R8
    AST_WR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        $countones(wr_en) <= 2 && (wr_en[WE_B] || !wr_en[WE_A] || $countones(wr_en) == 1 || wr_en[WE_B])); // R1
    AST_PAIR_ONLY_AB: assert property (@(posedge clk) disable iff (rst)
        ($countones(wr_en) == 2) |-> (wr_en[WE_A] && wr_en[WE_B])); // R1
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (wr_en == '0 && !taken && next_pc == snap.pc)); // R7
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> $stable(snap));                       // R9
    AST_NO_EARLY_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && !finish) |=> busy);                                // R9

endmodule

// File: tb/sim_loop_branch_unit.sv
`timescale 1ns/1ps
module sim_loop_branch_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  postbyte, offset_lo;
    logic [15:0] pc;
    logic [7:0]  reg_a, reg_b;
    logic [15:0] reg_x, reg_y, reg_sp;
    logic        done, illegal, taken;
    logic [15:0] next_pc;
    logic [4:0]  wr_en;
    logic [7:0]  wr_a, wr_b;
    logic [15:0] wr_w;

    always #2 clk = ~clk;

    loop_branch_unit u0 (
        .clk(clk), .rst(rst), .start(start), .postbyte(postbyte),
        .offset_lo(offset_lo), .pc(pc), .reg_a(reg_a), .reg_b(reg_b),
        .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .done(done),
        .illegal(illegal), .taken(taken), .next_pc(next_pc),
        .wr_en(wr_en), .wr_a(wr_a), .wr_b(wr_b), .wr_w(wr_w)
    );

    int checks = 0;
    int fails  = 0;
    bit over   = 0;

    logic [7:0]  ma, mb;
    logic [15:0] mx, my, msp;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] operand_of(input logic [2:0] sel);
        case (sel)
            3'd0:    return {8'h00, ma};
            3'd1:    return {8'h00, mb};
            3'd4:    return {ma, mb};
            3'd5:    return mx;
            3'd6:    return my;
            3'd7:    return msp;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic run_op(input logic [7:0] pb, input logic [7:0] off,
                          input logic [15:0] pcv, input string req,
                          input bit overlap);
        logic [2:0]  sel;
        logic [1:0]  op;
        bit          ill, nar, tk;
        logic [15:0] r, npc;
        logic [4:0]  we;
        logic [7:0]  ea, eb;
        bit          early;
        sel = pb[2:0];
        op  = pb[7:6];
        ill = (op == 2'b11) || (sel == 3'd2) || (sel == 3'd3);
        nar = (sel == 3'd0) || (sel == 3'd1);
        r   = operand_of(sel);
        if (op == 2'b00) r = r - 16'd1;
        else if (op == 2'b10) r = r + 16'd1;
        if (nar) r[15:8] = 8'h00;
        tk  = !ill && (pb[5] ? (r != 16'd0) : (r == 16'd0));
        npc = ill ? pcv : (pcv + 16'd3 + (tk ? {{7{pb[4]}}, pb[4], off} : 16'd0));
        we  = 5'b0;
        if (!ill && op != 2'b01) begin
            case (sel)
                3'd0: we = 5'b00001;
                3'd1: we = 5'b00010;
                3'd4: we = 5'b00011;
                3'd5: we = 5'b00100;
                3'd6: we = 5'b01000;
                default: we = 5'b10000;
            endcase
        end
        ea = (sel == 3'd4) ? r[15:8] : r[7:0];
        eb = r[7:0];

        postbyte = pb; offset_lo = off; pc = pcv;
        reg_a = ma; reg_b = mb; reg_x = mx; reg_y = my; reg_sp = msp;
        start = 1'b1;
        early = 0;
        @(negedge clk);
        start = 1'b0;
        early |= done;
        if (overlap) begin
            postbyte = pb ^ 8'h20; pc = pcv ^ 16'h5555; reg_x = ~mx; reg_a = ~ma;
            start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        early |= done;
        @(negedge clk);
        early |= done;
        chk("R8", "done before third edge", {31'b0, early}, 32'd0);
        @(negedge clk);
        chk("R8", "done on third edge", {31'b0, done}, 32'd1);
        chk(req, "illegal", {31'b0, illegal}, {31'b0, ill});
        chk(req, "taken", {31'b0, taken}, {31'b0, tk});
        chk(req, "next_pc", {16'b0, next_pc}, {16'b0, npc});
        chk(req, "wr_en", {27'b0, wr_en}, {27'b0, we});
        if (we[0]) chk(req, "wr_a", {24'b0, wr_a}, {24'b0, ea});
        if (we[1]) chk(req, "wr_b", {24'b0, wr_b}, {24'b0, eb});
        if (we[4] | we[3] | we[2]) chk(req, "wr_w", {16'b0, wr_w}, {16'b0, r});
        if (we[0]) ma = ea;
        if (we[1]) mb = eb;
        if (we[2]) mx = r;
        if (we[3]) my = r;
        if (we[4]) msp = r;
        if (overlap) begin
            early = 0;
            repeat (4) begin
                @(negedge clk);
                early |= done;
            end
            chk("R9", "extra done from ignored start", {31'b0, early}, 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!over) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pb;
        void'($urandom(32'd20240611));
        rst = 1'b1; start = 1'b0; postbyte = '0; offset_lo = '0; pc = '0;
        reg_a = '0; reg_b = '0; reg_x = '0; reg_y = '0; reg_sp = '0;
        ma = 8'h00; mb = 8'h00; mx = 16'h0; my = 16'h0; msp = 16'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8", "reset done", {31'b0, done}, 32'd0);
        chk("R8", "reset wr_en", {27'b0, wr_en}, 32'd0);

        // R3: A wraps at 8 bits, B untouched
        ma = 8'h00; mb = 8'h77;
        run_op(8'h20, 8'h10, 16'h1000, "R3", 0);
        // R1 R3: D borrow from B into A
        ma = 8'h01; mb = 8'h00;
        run_op(8'h24, 8'h08, 16'h2000, "R1", 0);
        // R2 R4: X increments through wrap to zero, branch on zero
        mx = 16'hFFFF;
        run_op(8'h85, 8'h40, 16'h3000, "R2", 0);
        // R4: both senses with Y reaching zero
        my = 16'h0001;
        run_op(8'h06, 8'h02, 16'h4000, "R4", 0);
        my = 16'h0001;
        run_op(8'h26, 8'h02, 16'h4000, "R4", 0);
        // R2: test only, no write
        msp = 16'h0000;
        run_op(8'h47, 8'h05, 16'h5000, "R2", 0);
        // R5: -256 with wrap below zero
        mx = 16'h0010;
        run_op(8'h35, 8'h00, 16'h0000, "R5", 0);
        // R5: +255 with wrap above 0xFFFF
        mb = 8'h10;
        run_op(8'h21, 8'hFF, 16'hFFF0, "R5", 0);
        // R6: bit 3 has no effect
        mx = 16'h1234;
        run_op(8'h25, 8'h20, 16'h6000, "R6", 0);
        mx = 16'h1234;
        run_op(8'h2D, 8'h20, 16'h6000, "R6", 0);
        // R7: illegal encodings
        run_op(8'hC0, 8'h11, 16'h7000, "R7", 0);
        run_op(8'h22, 8'h11, 16'h7100, "R7", 0);
        run_op(8'h13, 8'h11, 16'h7200, "R7", 0);
        // R9: start while busy ignored
        mx = 16'h0002;
        run_op(8'h25, 8'h30, 16'h8000, "R9", 1);

        for (int i = 0; i < 300; i++) begin
            pb = 8'($urandom);
            if (($urandom % 8) == 0) begin
                ma = 8'($urandom % 2); mb = 8'($urandom % 2);
                mx = 16'($urandom % 2); my = 16'hFFFF; msp = 16'($urandom % 2);
            end
            run_op(pb, 8'($urandom), 16'($urandom), "R1", 0);
        end

        over = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule